// File: doc/BRIEF.md
# Standby-Gated Hierarchical Reset Controller

This block lets software put one cluster of four cores, or any single core in it, into reset and keep it there until software lets it go. Software writes a 9-bit hold word through a one-cycle register port. The word has three levels of request: one bit for the whole cluster, one power-on reset bit per core, and one core reset bit per core. The block drives the matching reset lines and a status word that shows which resets are actually applied at that moment. Reading the port returns the hold word as it was last written, not the applied resets.

A reset is never applied to a core that is still running. A request waits until that core reports standby-in-wait-for-interrupt. A cluster request waits until all four cores report it. The levels imply one another: a cluster reset brings power-on reset on every core, and a power-on reset brings core reset on the same core. A lower level is not released while a higher level that covers it is still applied. Every applied reset lasts at least a minimum number of cycles (16 by default). A release requested inside that window waits for the window to end, and writing the bit back to 1 inside the window cancels the release.

Each of the nine reset lines has its own small state machine with four states: idle, waiting for standby, minimum hold, and held. The standby inputs are synchronous to `clk`.

Top module: `wfi_reset_ctrl`

## Requirements
- R1: On `rst` the hold word becomes {`cfg_cluster_on`, 8'b0}, every reset output is low and `status` is 0.
- R2: `rd_data` returns the last value written on `wr_data`, whatever resets are applied. The hold word updates on the edge where `wr_en` is high.
- R3: Field layout of the hold word and of `status`: bit 8 is cluster, bits 7:4 are power-on reset for cores 3..0, and bits 3:0 are core reset for cores 3..0. Core n sits on bit n of each per-core field. `status` equals {`cluster_rst`, `por_rst`, `core_rst`}.
- R4: A core or power-on reset request for core n is not applied while `standby[n]` is low. When `standby[n]` is already high, the output rises on the second clock edge after the write edge. When `standby[n]` rises later, the output rises on the first edge that samples it high.
- R5: The cluster reset is applied only on an edge where all four `standby` bits are high. Lower-level resets of cores that are already in standby may be applied before that.
- R6: Once applied, a reset stays high for at least MIN_HOLD (16) consecutive cycles, even when its request is cleared at once.
- R7: If the request is cleared after the minimum hold has elapsed, the output falls on the first edge after the edge that wrote the clear.
- R8: If the request is written back to 1 during the minimum hold, after having been cleared, the reset stays applied.
- R9: A request that is cleared while it is still waiting for standby is never applied, including after standby later rises.
- R10: Once serviced with all standby bits high, `status` equals {C, C?4'hF:P, C?4'hF:(P|R)}, where C, P and R are the written cluster, power-on and core fields.
- R11: A lower-level reset is not released while a higher-level reset covering the same core is applied. When both are released together, the lower one falls one edge after the higher one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cluster_on | input | 1 | Static value loaded into the cluster hold bit on reset |
| wr_en | input | 1 | Write strobe for the hold word |
| wr_data | input | 9 | Hold word to write |
| rd_data | output | 9 | Hold word as last written |
| standby | input | 4 | Per-core standby-in-wait-for-interrupt indication |
| core_rst | output | 4 | Per-core core reset, active high |
| por_rst | output | 4 | Per-core power-on reset, active high |
| cluster_rst | output | 1 | Cluster reset, active high |
| status | output | 9 | Resets currently applied, same layout as the hold word |

## Verification
A write lands in `rd_data` one edge after the write strobe is sampled. The reset it requests then appears one edge later, or on the first edge that sees the needed standby. It falls one edge after a clear that arrives past the minimum hold, and one more edge later at each lower level. The bench drives on one falling edge and samples on the next, so each check lines up with the edge count stated in its requirement. The checks on the minimum hold, write-back and withdrawal count samples over a fixed window instead of looking at a single instant. The exhaustive sweep over all 512 hold values waits 40 cycles after each write, which is longer than any release chain, before it compares against the computed formula.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

    parameter int CORES  = 4;
    parameter int HOLD_W = 2 * CORES + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MIN  = 2'd2,
        ST_HELD = 2'd3
    } lvl_state_e;

    // R3: field layout, cluster on top, core reset at the bottom
    typedef struct packed {
        logic             cluster;
        logic [CORES-1:0] por;
        logic [CORES-1:0] core;
    } hold_t;

    // Expand written fields into the effective request of every line.
    function automatic hold_t implied_req(input hold_t h);
        hold_t r;
        r.cluster = h.cluster;
        r.por     = h.por | {CORES{h.cluster}};
        r.core    = h.core | r.por;
        return r;
    endfunction

endpackage

// File: rtl/wrc_hold_reg.sv
module wrc_hold_reg
    import wrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cluster_on,
    input  logic              wr_en,
    input  logic [HOLD_W-1:0] wr_data,
    output hold_t             hold_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q         <= '0;
            hold_q.cluster <= cfg_cluster_on;
        end else if (wr_en) begin
            hold_q <= hold_t'(wr_data);
        end
    end

    // R2
    hold_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (hold_q == $past(wr_data)));

endmodule

// File: rtl/wrc_level_fsm.sv
module wrc_level_fsm
    import wrc_pkg::*;
#(
    parameter int MIN_HOLD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic req,     // effective request for this line
    input  logic go,      // standby satisfied or higher level applied
    input  logic higher,  // a higher level covering this line is applied
    output logic rst_out
);

    localparam int CNT_W = (MIN_HOLD > 2) ? $clog2(MIN_HOLD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_HOLD - 1);
    localparam int RUN_W = $clog2(MIN_HOLD) + 1;

    lvl_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (req) state_d = go ? ST_MIN : ST_WAIT;
            end
            ST_WAIT: begin
                cnt_d = '0;
                if (!req)    state_d = ST_IDLE;
                else if (go) state_d = ST_MIN;
            end
            ST_MIN: begin
                if (cnt_q == CNT_LAST)
                    state_d = (req || higher) ? ST_HELD : ST_IDLE;
                else
                    cnt_d = cnt_q + 1'b1;
            end
            ST_HELD: begin
                if (!req && !higher) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rst_out <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rst_out <= (state_d == ST_MIN) || (state_d == ST_HELD);
        end
    end

    // Independent run-length of the applied reset, used only by checks.
    logic [RUN_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst || !rst_out)         run_len <= '0;
        else if (run_len != RUN_W'(MIN_HOLD)) run_len <= run_len + 1'b1;
    end

    // R4
    rise_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out) |-> $past(req && go));

    // R6
    min_assert_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out) |-> ($past(run_len) >= RUN_W'(MIN_HOLD - 1)));

    // R11
    fall_needs_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out) |-> $past(!req && !higher));

endmodule

// File: rtl/wfi_reset_ctrl.sv
module wfi_reset_ctrl
    import wrc_pkg::*;
#(
    parameter int MIN_HOLD = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cluster_on,
    input  logic              wr_en,
    input  logic [HOLD_W-1:0] wr_data,
    output logic [HOLD_W-1:0] rd_data,
    input  logic [CORES-1:0]  standby,
    output logic [CORES-1:0]  core_rst,
    output logic [CORES-1:0]  por_rst,
    output logic              cluster_rst,
    output logic [HOLD_W-1:0] status
);

    hold_t hold_q;
    hold_t req;

    wrc_hold_reg u_hold (
        .clk            (clk),
        .rst            (rst),
        .cfg_cluster_on (cfg_cluster_on),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .hold_q         (hold_q)
    );

    assign req     = implied_req(hold_q);
    assign rd_data = hold_q;

    wrc_level_fsm #(.MIN_HOLD(MIN_HOLD)) u_cluster (
        .clk     (clk),
        .rst     (rst),
        .req     (req.cluster),
        .go      (&standby),
        .higher  (1'b0),
        .rst_out (cluster_rst)
    );

    for (genvar n = 0; n < CORES; n++) begin : g_core
        wrc_level_fsm #(.MIN_HOLD(MIN_HOLD)) u_por (
            .clk     (clk),
            .rst     (rst),
            .req     (req.por[n]),
            .go      (standby[n] | cluster_rst),
            .higher  (cluster_rst),
            .rst_out (por_rst[n])
        );
        wrc_level_fsm #(.MIN_HOLD(MIN_HOLD)) u_core (
            .clk     (clk),
            .rst     (rst),
            .req     (req.core[n]),
            .go      (standby[n] | por_rst[n] | cluster_rst),
            .higher  (por_rst[n] | cluster_rst),
            .rst_out (core_rst[n])
        );
    end

    assign status = {cluster_rst, por_rst, core_rst};

    // R11
    cluster_covers_por_chk: assert property (@(posedge clk) disable iff (rst)
        cluster_rst |-> (&por_rst));

    // R11
    por_covers_core_chk: assert property (@(posedge clk) disable iff (rst)
        ((por_rst & ~core_rst) == '0));

    // R5
    cluster_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cluster_rst) |-> $past(&standby));

endmodule

// File: tb/wfi_reset_ctrl_tb_top.sv
module wfi_reset_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_cluster_on;
    logic       wr_en;
    logic [8:0] wr_data;
    logic [8:0] rd_data;
    logic [3:0] standby;
    logic [3:0] core_rst;
    logic [3:0] por_rst;
    logic       cluster_rst;
    logic [8:0] status;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    wfi_reset_ctrl dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_cluster_on (cfg_cluster_on),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .standby        (standby),
        .core_rst       (core_rst),
        .por_rst        (por_rst),
        .cluster_rst    (cluster_rst),
        .status         (status)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [8:0] exp_status(input logic [8:0] v);
        logic       c;
        logic [3:0] p, r;
        c = v[8];
        p = c ? 4'hF : v[7:4];
        r = c ? 4'hF : (v[7:4] | v[3:0]);
        return {c, p, r};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst = 1'b1;
        cfg_cluster_on = 1'b1;
        wr_en = 1'b0;
        wr_data = '0;
        standby = 4'b0000;
        idle(3);
        rst = 1'b0;

        // R1: power-on hold word and quiet outputs
        check("R1 hold", rd_data, 9'h100);
        check("R1 status", status, 9'h000);
        idle(5);
        check("R5 cluster waits standby", status, 9'h000);
        wr(9'h000);
        check("R2 readback cleared", rd_data, 9'h000);

        // R4: gating on standby, then rise on the first edge seeing standby
        wr(9'h002);
        check("R2 readback", rd_data, 9'h002);
        idle(5);
        check("R4 gated", status, 9'h000);
        standby[1] = 1'b1;
        @(negedge clk);
        check("R4 rise after standby", {5'b0, core_rst}, 9'h002);
        wr(9'h000);
        idle(20);
        check("R4 released", status, 9'h000);

        // R4: standby already high, rise on second edge after write
        wr(9'h002);
        check("R4 not yet", status, 9'h000);
        @(negedge clk);
        check("R4 second edge", status, 9'h002);

        // R6: clear at once, count applied cycles
        cnt = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (core_rst[1]) cnt++;
            wr_en = (i == 0);
            wr_data = 9'h000;
        end
        wr_en = 1'b0;
        check("R6 minimum hold", 9'(cnt), 9'd16);

        // R8: write-back during minimum hold cancels release
        wr(9'h002);
        idle(3);
        wr(9'h000);
        idle(3);
        wr(9'h002);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!core_rst[1]) cnt++;
        end
        check("R8 write-back keeps reset", 9'(cnt), 9'd0);

        // R7: clear after minimum hold, falls one edge later
        wr(9'h000);
        check("R7 still high at clear edge", status, 9'h002);
        @(negedge clk);
        check("R7 released", status, 9'h000);

        // R9: withdraw while waiting for standby
        standby[2] = 1'b0;
        wr(9'h004);
        idle(4);
        wr(9'h000);
        idle(2);
        standby[2] = 1'b1;
        cnt = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (core_rst[2]) cnt++;
        end
        check("R9 withdrawn never applied", 9'(cnt), 9'd0);

        // R5: cluster waits for all four standby bits
        standby = 4'b0111;
        wr(9'h100);
        idle(20);
        check("R5 cluster gated", {8'b0, cluster_rst}, 9'h000);
        check("R5 standby cores applied", status, 9'h077);
        standby = 4'b1111;
        @(negedge clk);
        check("R5 cluster applied", status, 9'h1FF);
        wr(9'h000);
        idle(40);
        check("R5 cluster released", status, 9'h000);

        // R11: lower bit cleared while power-on reset still held
        wr(9'h011);
        idle(20);
        check("R11 both applied", status, 9'h011);
        wr(9'h010);
        idle(20);
        check("R11 core held by por", status, 9'h011);
        wr(9'h000);
        @(negedge clk);
        check("R11 por first", status, 9'h001);
        @(negedge clk);
        check("R11 core one edge later", status, 9'h000);

        // R3 R10 R2: exhaustive sweep of hold words with all cores in standby
        for (int v = 0; v < 512; v++) begin
            wr(9'(v));
            check("R2 sweep readback", rd_data, 9'(v));
            idle(40);
            check("R10 R3 sweep status", status, exp_status(9'(v)));
            check("R3 status layout", status, {cluster_rst, por_rst, core_rst});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule